// File: doc/BRIEF.md
# SECDED Byte Codec

This block guards one data byte held in memory. Its encoder side is combinational. It turns a byte into a 13-bit stored word, and the bit numbered p of that word sits at vector index p. Four Hamming check bits take the power-of-two positions. The byte's bits fill the remaining positions from 3 to 12. An overall parity bit at position 0 then brings the whole word to the chosen parity sense.

The decoder side takes a word read back from storage. It recomputes the check bits from the data positions and forms a 4-bit syndrome. It then sorts the word into one of four outcomes:

- clean;
- one bit in error, which is repaired;
- one bit in error that lies in a check bit or in the parity bit, which is repaired and also marked as such;
- uncorrectable.

The decoder returns the byte with all redundancy removed, one clock after a read is presented. A single parameter selects odd or even parity. The encoder and the decoder always use the same sense.

Top module: `hamming_secded_codec`

## Requirements
- R1: `enc_word_o` is a combinational function of `enc_data_i`. Data bit i (i = 0..7) appears at word positions 3, 5, 6, 7, 9, 10, 11 and 12 respectively, and word position p is vector index p.
- R2: The check bit at position 2^k (k = 0..3) is set so that it and every data position whose index has bit k set together hold an odd count of ones when `ODD_SENSE` = 1, or an even count when `ODD_SENSE` = 0.
- R3: Position 0 is set so that the count of ones over all 13 word bits is odd when `ODD_SENSE` = 1 and even when `ODD_SENSE` = 0.
- R4: A cycle with `rd_valid_i` high at a rising edge raises `dec_valid_o` for exactly the following cycle, with the results for that word. After a cycle with `rd_valid_i` low, `dec_valid_o` is low and every other decoder output keeps its previous value.
- R5: Bit k of `dec_syndrome_o` is 1 when the stored check bit at position 2^k differs from the value recomputed from the read data positions. For a single flipped bit at position p in 1..12, the syndrome equals p, and a flip at position 0 gives a syndrome of 0.
- R6: A word with a zero syndrome and correct overall parity returns its data positions unchanged, with `dec_sec_o`, `dec_ded_o` and `dec_chkbit_o` all 0.
- R7: A syndrome in 1..12 with failing overall parity inverts the bit at the position given by the syndrome before the data is extracted, and sets `dec_sec_o`. `dec_chkbit_o` is 1 exactly when the syndrome has one bit set, meaning a check bit was hit.
- R8: A zero syndrome with failing overall parity leaves the data unchanged and sets both `dec_sec_o` and `dec_chkbit_o`.
- R9: A nonzero syndrome with passing overall parity sets `dec_ded_o` and clears `dec_sec_o` and `dec_chkbit_o`. The data is returned exactly as read, with no inversion.
- R10: A syndrome of 13, 14 or 15 with failing overall parity sets `dec_ded_o`, clears `dec_sec_o` and `dec_chkbit_o`, and applies no inversion.
- R11: A synchronous active-high `rst_i` drives `dec_valid_o`, `dec_data_o`, `dec_sec_o`, `dec_ded_o`, `dec_chkbit_o` and `dec_syndrome_o` to 0. `dec_sec_o` and `dec_ded_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| enc_data_i | input | 8 | Byte to encode |
| enc_word_o | output | 13 | Encoded word; index p is word position p |
| rd_valid_i | input | 1 | Read word present this cycle |
| rd_word_i | input | 13 | Word read back from storage |
| dec_valid_o | output | 1 | Decoder results valid |
| dec_data_o | output | 8 | Byte after correction, redundancy removed |
| dec_sec_o | output | 1 | Single error found and repaired |
| dec_ded_o | output | 1 | Uncorrectable error detected |
| dec_chkbit_o | output | 1 | The repaired bit was a check bit or the parity bit |
| dec_syndrome_o | output | 4 | Raw syndrome {S8, S4, S2, S1} |

## Verification
The bench builds two copies of the block, one with `ODD_SENSE` = 1 and one with `ODD_SENSE` = 0. Both copies receive the same bytes and the same error masks, so the two parity senses are compared on identical traffic. This covers the polarity of every check bit and of the overall parity bit, which a single sense would leave half unexercised. Every byte value is run clean and with each of the 13 single flips. A set of double flips and of chosen check-bit flips drives the syndrome to 13, 14 and 15, a region no single error can reach.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W  = 8;
    localparam int SYN_W   = 4;
    localparam int CODE_W  = DATA_W + SYN_W + 1;
    localparam int MAX_POS = CODE_W - 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYN_W-1:0]  syn_t;

    // Result of classifying one read word
    typedef struct packed {
        data_t data;
        logic  fixed;
        logic  fatal;
        logic  meta;
        syn_t  syn;
    } dec_res_t;

    function automatic bit is_pow2(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Word position that carries data bit idx
    function automatic int data_slot(int idx);
        int cnt;
        int slot;
        cnt  = 0;
        slot = 0;
        for (int p = 1; p <= MAX_POS; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == idx) slot = p;
                cnt++;
            end
        end
        return slot;
    endfunction

    // XOR of data positions in each check group, no sense applied
    function automatic syn_t group_xor(code_t w);
        syn_t acc;
        acc = '0;
        for (int k = 0; k < SYN_W; k++) begin
            for (int p = 3; p <= MAX_POS; p++) begin
                if (!is_pow2(p) && (((p >> k) & 1) == 1)) acc[k] = acc[k] ^ w[p];
            end
        end
        return acc;
    endfunction

    function automatic code_t place_data(data_t d);
        code_t w;
        w = '0;
        for (int i = 0; i < DATA_W; i++) w[data_slot(i)] = d[i];
        return w;
    endfunction

    function automatic data_t pull_data(code_t w);
        data_t d;
        for (int i = 0; i < DATA_W; i++) d[i] = w[data_slot(i)];
        return d;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
#(
    parameter bit ODD_SENSE = 1'b1
) (
    input  data_t data_i,
    output code_t code_o
);

    localparam syn_t SENSE_MASK = {SYN_W{ODD_SENSE}};

    syn_t  chk;
    code_t body;

    always_comb begin
        body = place_data(data_i);
        chk  = group_xor(body) ^ SENSE_MASK;
        for (int k = 0; k < SYN_W; k++) body[1 << k] = chk[k];
        body[0] = (^body[MAX_POS:1]) ^ ODD_SENSE;
        code_o  = body;
    end

endmodule

// File: rtl/secded_check.sv
module secded_check
    import secded_pkg::*;
#(
    parameter bit ODD_SENSE = 1'b1
) (
    input  code_t code_i,
    output syn_t  syn_o,
    output logic  par_fail_o
);

    localparam syn_t SENSE_MASK = {SYN_W{ODD_SENSE}};

    syn_t stored;

    for (genvar k = 0; k < SYN_W; k++) begin : g_stored
        assign stored[k] = code_i[1 << k];
    end

    assign syn_o      = stored ^ group_xor(code_i) ^ SENSE_MASK;
    assign par_fail_o = (^code_i) != ODD_SENSE;

endmodule

// File: rtl/secded_correct.sv
module secded_correct
    import secded_pkg::*;
(
    input  code_t    code_i,
    input  syn_t     syn_i,
    input  logic     par_fail_i,
    output dec_res_t res_o
);

    code_t fixed_w;

    always_comb begin
        fixed_w     = code_i;
        res_o.fixed = 1'b0;
        res_o.fatal = 1'b0;
        res_o.meta  = 1'b0;
        if (syn_i == '0) begin
            if (par_fail_i) begin
                res_o.fixed = 1'b1;
                res_o.meta  = 1'b1;
            end
        end else if (!par_fail_i) begin
            res_o.fatal = 1'b1;
        end else if (int'(syn_i) > MAX_POS) begin
            res_o.fatal = 1'b1;
        end else begin
            res_o.fixed = 1'b1;
            res_o.meta  = $onehot(syn_i);
            fixed_w     = code_i ^ (code_t'(1) << syn_i);
        end
        res_o.data = pull_data(fixed_w);
        res_o.syn  = syn_i;
    end

endmodule

// File: rtl/hamming_secded_codec.sv
module hamming_secded_codec
    import secded_pkg::*;
#(
    parameter bit ODD_SENSE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_word_o,
    input  logic              rd_valid_i,
    input  logic [CODE_W-1:0] rd_word_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_sec_o,
    output logic              dec_ded_o,
    output logic              dec_chkbit_o,
    output logic [SYN_W-1:0]  dec_syndrome_o
);

    syn_t     syn;
    logic     par_fail;
    dec_res_t res;

    secded_encoder #(.ODD_SENSE(ODD_SENSE)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_word_o)
    );

    secded_check #(.ODD_SENSE(ODD_SENSE)) u_chk (
        .code_i     (rd_word_i),
        .syn_o      (syn),
        .par_fail_o (par_fail)
    );

    secded_correct u_fix (
        .code_i     (rd_word_i),
        .syn_i      (syn),
        .par_fail_i (par_fail),
        .res_o      (res)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dec_valid_o    <= 1'b0;
            dec_data_o     <= '0;
            dec_sec_o      <= 1'b0;
            dec_ded_o      <= 1'b0;
            dec_chkbit_o   <= 1'b0;
            dec_syndrome_o <= '0;
        end else begin
            dec_valid_o <= rd_valid_i;
            if (rd_valid_i) begin
                dec_data_o     <= res.data;
                dec_sec_o      <= res.fixed;
                dec_ded_o      <= res.fatal;
                dec_chkbit_o   <= res.meta;
                dec_syndrome_o <= res.syn;
            end
        end
    end

    // R3
    enc_overall_parity_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (^enc_word_o) == ODD_SENSE);

    // R4
    valid_follows_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_i |=> dec_valid_o);

    // R4
    valid_drops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_valid_i |=> !dec_valid_o);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o)
                         && $stable(dec_sec_o) && $stable(dec_ded_o)));

    // R11
    flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(dec_sec_o && dec_ded_o));

    // R8
    chkbit_needs_sec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_chkbit_o |-> dec_sec_o);

    // R9
    zero_syn_not_fatal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec_valid_o && dec_syndrome_o == '0) |-> !dec_ded_o);

    // R10
    wide_syn_fatal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec_valid_o && dec_syndrome_o > 4'd12) |-> dec_ded_o);

endmodule

// File: tb/test_hamming_secded_codec.sv
`timescale 1ns/1ps
module test_hamming_secded_codec;

    typedef struct packed {
        logic [7:0] data;
        logic       sec;
        logic       ded;
        logic       chk;
        logic [3:0] syn;
    } res_t;

    typedef struct {
        res_t  o;
        res_t  e;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  enc_data = '0;
    logic [12:0] enc_word_odd, enc_word_even;
    logic        rd_valid = 1'b0;
    logic [12:0] rd_word_odd = '0, rd_word_even = '0;
    logic        v_o, v_e;
    logic [7:0]  d_o, d_e;
    logic        sec_o, sec_e, ded_o, ded_e, cb_o, cb_e;
    logic [3:0]  syn_o, syn_e;

    int   checks = 0;
    int   fails  = 0;
    bit   running = 1'b0;
    item_t q[$];
    res_t last_o = '0, last_e = '0;

    always #2.5 clk = ~clk;

    hamming_secded_codec #(.ODD_SENSE(1'b1)) i_hamming_secded_codec (
        .clk_i(clk), .rst_i(rst), .enc_data_i(enc_data), .enc_word_o(enc_word_odd),
        .rd_valid_i(rd_valid), .rd_word_i(rd_word_odd), .dec_valid_o(v_o),
        .dec_data_o(d_o), .dec_sec_o(sec_o), .dec_ded_o(ded_o),
        .dec_chkbit_o(cb_o), .dec_syndrome_o(syn_o));

    hamming_secded_codec #(.ODD_SENSE(1'b0)) i_hamming_secded_codec_even (
        .clk_i(clk), .rst_i(rst), .enc_data_i(enc_data), .enc_word_o(enc_word_even),
        .rd_valid_i(rd_valid), .rd_word_i(rd_word_even), .dec_valid_o(v_e),
        .dec_data_o(d_e), .dec_sec_o(sec_e), .dec_ded_o(ded_e),
        .dec_chkbit_o(cb_e), .dec_syndrome_o(syn_e));

    function automatic int slot(int i);
        int tbl [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return tbl[i];
    endfunction

    // Model of R1, R2, R3
    function automatic logic [12:0] m_encode(logic [7:0] d, bit s);
        logic [12:0] w;
        logic c;
        w = '0;
        for (int i = 0; i < 8; i++) w[slot(i)] = d[i];
        for (int k = 0; k < 4; k++) begin
            c = s;
            for (int i = 0; i < 8; i++) if (((slot(i) >> k) & 1) == 1) c = c ^ d[i];
            w[1 << k] = c;
        end
        w[0] = s ^ (^w[12:1]);
        return w;
    endfunction

    // Model of R5..R10 built on syndrome linearity
    function automatic res_t m_decode(logic [7:0] d, logic [12:0] f, bit s);
        res_t r;
        logic [12:0] w;
        logic [3:0] sy;
        int n;
        bit pf;
        w = m_encode(d, s) ^ f;
        sy = '0;
        n = 0;
        for (int p = 0; p < 13; p++) if (f[p]) begin
            n++;
            sy = sy ^ 4'(p);
        end
        pf = (n % 2) == 1;
        r.sec = 1'b0; r.ded = 1'b0; r.chk = 1'b0; r.syn = sy;
        if (sy == 0) begin
            if (pf) begin r.sec = 1'b1; r.chk = 1'b1; end
        end else if (!pf || sy > 12) begin
            r.ded = 1'b1;
        end else begin
            r.sec = 1'b1;
            r.chk = (sy == 1 || sy == 2 || sy == 4 || sy == 8);
            w[sy] = ~w[sy];
        end
        for (int i = 0; i < 8; i++) r.data[i] = w[slot(i)];
        return r;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_res(string tag, string inst, res_t a, res_t x);
        check(tag, {inst, " data"}, a.data, x.data);
        check(tag, {inst, " sec"}, a.sec, x.sec);
        check(tag, {inst, " ded"}, a.ded, x.ded);
        check(tag, {inst, " chkbit"}, a.chk, x.chk);
        check("R5", {inst, " syndrome"}, a.syn, x.syn);
    endtask

    task automatic send(logic [7:0] d, logic [12:0] f, string tag);
        item_t it;
        @(negedge clk);
        rd_word_odd  = m_encode(d, 1'b1) ^ f;
        rd_word_even = m_encode(d, 1'b0) ^ f;
        rd_valid = 1'b1;
        it.o = m_decode(d, f, 1'b1);
        it.e = m_decode(d, f, 1'b0);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            rd_valid = 1'b0;
            rd_word_odd = 13'h1fff;
            rd_word_even = 13'h1fff;
        end
    endtask

    // Monitor: pops expected items as results appear; checks hold when idle
    always @(negedge clk) begin
        if (running && !rst) begin
            res_t ao, ae;
            ao = '{d_o, sec_o, ded_o, cb_o, syn_o};
            ae = '{d_e, sec_e, ded_e, cb_e, syn_e};
            check("R4", "valid agreement", v_o, v_e);
            if (v_o) begin
                if (q.size() == 0) begin
                    check("R4", "unexpected valid", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    cmp_res(it.tag, "odd", ao, it.o);
                    cmp_res(it.tag, "even", ae, it.e);
                    last_o = it.o;
                    last_e = it.e;
                end
            end else begin
                check("R4", "odd hold", int'(ao), int'(last_o));
                check("R4", "even hold", int'(ae), int'(last_e));
            end
        end
    end

    task automatic check_reset_state();
        check("R11", "valid", {v_o, v_e}, 0);
        check("R11", "data", {d_o, d_e}, 0);
        check("R11", "flags", {sec_o, ded_o, cb_o, sec_e, ded_e, cb_e}, 0);
        check("R11", "syndrome", {syn_o, syn_e}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("WATCHDOG", "run finished", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #0.5 check_reset_state();

        // Encoder, both senses, every byte
        for (int d = 0; d < 256; d++) begin
            logic [12:0] xo, xe;
            enc_data = 8'(d);
            #1;
            xo = m_encode(8'(d), 1'b1);
            xe = m_encode(8'(d), 1'b0);
            check("R1", "odd data positions", int'(enc_word_odd & 13'h1ee8), int'(xo & 13'h1ee8));
            check("R1", "even data positions", int'(enc_word_even & 13'h1ee8), int'(xe & 13'h1ee8));
            check("R2", "odd check bits", int'(enc_word_odd & 13'h0116), int'(xo & 13'h0116));
            check("R2", "even check bits", int'(enc_word_even & 13'h0116), int'(xe & 13'h0116));
            check("R3", "odd parity bit", enc_word_odd[0], xo[0]);
            check("R3", "even parity bit", enc_word_even[0], xe[0]);
        end
        enc_data = 8'h00;
        #1;
        check("R2", "zero byte odd word", enc_word_odd, 13'h117);
        check("R2", "zero byte even word", enc_word_even, 13'h000);

        running = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 256; d++) send(8'(d), 13'h0, "R6");
        idle(3);
        for (int d = 0; d < 256; d++)
            for (int p = 0; p < 13; p++)
                send(8'(d), 13'(1) << p, (p == 0) ? "R8" : "R7");
        idle(2);
        for (int d = 0; d < 256; d += 17)
            for (int p = 0; p < 13; p++)
                for (int r = p + 1; r < 13; r++)
                    send(8'(d), (13'(1) << p) | (13'(1) << r), "R9");
        idle(1);
        for (int d = 0; d < 256; d += 5) begin
            send(8'(d), 13'h112, "R10");
            send(8'(d), 13'h114, "R10");
            send(8'(d), 13'h117, "R10");
        end
        idle(3);
        check("R4", "queue drained", q.size(), 0);

        // Reset after traffic
        send(8'hA5, 13'h0, "R6");
        @(negedge clk);
        rd_valid = 1'b1;
        rst = 1'b1;
        running = 1'b0;
        q.delete();
        @(negedge clk);
        rd_valid = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        last_o = '0;
        last_e = '0;
        idle(2);
        check_reset_state();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule